// File: doc/BRIEF.md
# DMA Channel Enable and Error Status Bank

This block keeps the run state of a DMA controller's channels. For each implemented channel it holds an enable bit and a descriptor-select bit. The descriptor-select bit is 0 for the primary descriptor and 1 for the alternate one. Software changes both kinds of bit through paired write-one-to-set and write-one-to-clear registers, so it never needs a read-modify-write. A single sticky bus-error flag sits beside them.

The transfer engine reports events on a strobe interface. It gives a channel index and one strobe for each event kind: cycle completed, descriptor fetched with a stop code, and bus error. Any of these strobes drops the enable of the named channel. A bus error also raises the error flag. When a hardware disable and a software action collide in the same cycle, the hardware outcome is kept.

Register accesses use one selector. Writes are synchronous. Reads are combinational from the registered state. The enable vector, the select vector and the error flag also leave the block directly on their own outputs.

Top module: `dma_chan_ctrl_bank`

## Requirements
- R1: After reset, every enable bit, every descriptor-select bit and the error flag are 0.
- R2: A write to selector 0 sets the enable of each channel whose data bit is 1. Channels whose data bit is 0 keep their state. A read of selector 0 returns the enable vector with channel n at bit n.
- R3: A write to selector 1 clears the enable of each channel whose data bit is 1. Channels whose data bit is 0 are unchanged. A read of selector 1 returns 0.
- R4: A cycle-done strobe clears the enable of the channel given by the index one clock later. No other enable changes.
- R5: A stop-descriptor strobe clears the enable of the indexed channel in the same way.
- R6: A bus-error strobe clears the enable of the indexed channel and sets the error flag one clock later.
- R7: When a hardware disable and a selector-0 write that sets the same channel occur in the same cycle, the channel ends up disabled.
- R8: A write to selector 2 moves each channel whose data bit is 1 to the alternate descriptor (bit = 1). A write to selector 3 moves each such channel back to the primary descriptor (bit = 0). Hardware events never change these bits. A read of selector 2 returns the select vector. A read of selector 3 returns 0.
- R9: A read of selector 4 returns the error flag in bit 0, with all other bits 0. Writing 1 to bit 0 of selector 4 clears the flag. Writing 0 leaves it unchanged. Once set, the flag holds until it is cleared.
- R10: A bus-error strobe in the same cycle as a clearing write to selector 4 leaves the error flag set.
- R11: Bits for channel numbers at or above the implemented count read as 0 and ignore writes. Events whose index is at or above that count disable nothing, although a bus error on such an index still sets the error flag.
- R12: Writes to selectors 5 to 7 change nothing, and reads of those selectors return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register selected by reg_sel |
| reg_sel | input | 3 | Register selector, used for both reads and writes |
| reg_wdata | input | VEC_W (32) | Write data, with bit n applying to channel n |
| reg_rdata | output | VEC_W (32) | Combinational read data for reg_sel |
| hw_chan | input | $clog2(VEC_W) (5) | Channel index for the hardware event strobes |
| hw_done | input | 1 | Cycle-complete strobe |
| hw_stop | input | 1 | Stop-code descriptor strobe |
| hw_buserr | input | 1 | Bus-error strobe |
| chan_en | output | NUM_CH (6) | Enable vector |
| alt_sel | output | NUM_CH (6) | Descriptor-select vector, 1 = alternate |
| err_flag | output | 1 | Sticky bus-error flag |

## Verification
Every register write and every hardware strobe takes effect at the clock edge where it is sampled. Its result therefore appears on chan_en, alt_sel and err_flag exactly one edge later. The same new value is seen through reg_rdata in that cycle without any further delay, because the read path has no register. The bench drives each stimulus on a falling edge and holds it across exactly one rising edge. It then compares the outputs and the readback on the following falling edge against a model advanced once per rising edge. Simultaneous-event cases are covered by placing both events in the same single-cycle step.

// File: rtl/dmaen_pkg.sv
package dmaen_pkg;

    // Register selector codes; the read mux and the write decoder both use them.
    typedef enum logic [2:0] {
        SEL_EN_SET  = 3'd0,
        SEL_EN_CLR  = 3'd1,
        SEL_ALT_SET = 3'd2,
        SEL_ALT_CLR = 3'd3,
        SEL_ERR     = 3'd4
    } reg_sel_e;

    localparam int REG_SEL_W = 3;

    // Build a mask with the lowest n bits set, w bits wide.
    function automatic logic [63:0] low_mask(input int n);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dmaen_wr_decode.sv
module dmaen_wr_decode
    import dmaen_pkg::*;
#(
    parameter int VEC_W = 32
) (
    input  logic                 reg_wr,
    input  logic [REG_SEL_W-1:0] reg_sel,
    input  logic [VEC_W-1:0]     reg_wdata,
    output logic [VEC_W-1:0]     en_set,
    output logic [VEC_W-1:0]     en_clr,
    output logic [VEC_W-1:0]     alt_set,
    output logic [VEC_W-1:0]     alt_clr,
    output logic                 err_clr
);

    always_comb begin
        en_set  = '0;
        en_clr  = '0;
        alt_set = '0;
        alt_clr = '0;
        err_clr = 1'b0;
        if (reg_wr) begin
            unique case (reg_sel)
                SEL_EN_SET:  en_set  = reg_wdata;
                SEL_EN_CLR:  en_clr  = reg_wdata;
                SEL_ALT_SET: alt_set = reg_wdata;
                SEL_ALT_CLR: alt_clr = reg_wdata;
                SEL_ERR:     err_clr = reg_wdata[0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dmaen_evt_decode.sv
module dmaen_evt_decode #(
    parameter int VEC_W  = 32,
    parameter int NUM_CH = 6,
    localparam int CH_W  = $clog2(VEC_W)
) (
    input  logic [CH_W-1:0]  hw_chan,
    input  logic             hw_done,
    input  logic             hw_stop,
    input  logic             hw_buserr,
    output logic [VEC_W-1:0] hw_kill
);

    logic any_evt;
    assign any_evt = hw_done | hw_stop | hw_buserr;

    // One decoder slice per vector bit; unimplemented slices stay at 0.
    for (genvar i = 0; i < VEC_W; i++) begin : g_slice
        if (i < NUM_CH) begin : g_impl
            assign hw_kill[i] = any_evt && (hw_chan == CH_W'(i));
        end else begin : g_none
            assign hw_kill[i] = 1'b0;
        end
    end

endmodule

// File: rtl/dmaen_setclr_bank.sv
module dmaen_setclr_bank
    import dmaen_pkg::*;
#(
    parameter int VEC_W  = 32,
    parameter int NUM_CH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] sw_set,
    input  logic [VEC_W-1:0] sw_clr,
    input  logic [VEC_W-1:0] hw_clr,
    output logic [VEC_W-1:0] bits
);

    localparam logic [VEC_W-1:0] IMPL_MASK = VEC_W'(low_mask(NUM_CH));

    typedef struct packed {
        logic [VEC_W-1:0] bits;
    } bank_st_t;

    bank_st_t st_d, st_q;

    // Hardware clear is applied last, so it wins over a same-cycle set.
    always_comb begin
        st_d      = st_q;
        st_d.bits = (st_q.bits | sw_set) & ~sw_clr;
        st_d.bits = st_d.bits & ~hw_clr;
        st_d.bits = st_d.bits & IMPL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits = st_q.bits;

endmodule

// File: rtl/dmaen_err_flag.sv
module dmaen_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_clr,
    input  logic hw_set,
    output logic flag
);

    typedef struct packed {
        logic flag;
    } err_st_t;

    err_st_t st_d, st_q;

    // A set from the bus has priority over a clear from software.
    always_comb begin
        st_d = st_q;
        if (sw_clr) st_d.flag = 1'b0;
        if (hw_set) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/dma_chan_ctrl_bank.sv
module dma_chan_ctrl_bank
    import dmaen_pkg::*;
#(
    parameter int VEC_W  = 32,
    parameter int NUM_CH = 6,
    localparam int CH_W  = $clog2(VEC_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [REG_SEL_W-1:0] reg_sel,
    input  logic [VEC_W-1:0]     reg_wdata,
    output logic [VEC_W-1:0]     reg_rdata,
    input  logic [CH_W-1:0]      hw_chan,
    input  logic                 hw_done,
    input  logic                 hw_stop,
    input  logic                 hw_buserr,
    output logic [NUM_CH-1:0]    chan_en,
    output logic [NUM_CH-1:0]    alt_sel,
    output logic                 err_flag
);

    logic [VEC_W-1:0] en_set, en_clr, alt_set, alt_clr, hw_kill;
    logic [VEC_W-1:0] en_vec, alt_vec;
    logic             err_clr, err_q;

    dmaen_wr_decode #(.VEC_W(VEC_W)) u_wdec (
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .en_set    (en_set),
        .en_clr    (en_clr),
        .alt_set   (alt_set),
        .alt_clr   (alt_clr),
        .err_clr   (err_clr)
    );

    dmaen_evt_decode #(.VEC_W(VEC_W), .NUM_CH(NUM_CH)) u_edec (
        .hw_chan   (hw_chan),
        .hw_done   (hw_done),
        .hw_stop   (hw_stop),
        .hw_buserr (hw_buserr),
        .hw_kill   (hw_kill)
    );

    dmaen_setclr_bank #(.VEC_W(VEC_W), .NUM_CH(NUM_CH)) u_en_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_set (en_set),
        .sw_clr (en_clr),
        .hw_clr (hw_kill),
        .bits   (en_vec)
    );

    dmaen_setclr_bank #(.VEC_W(VEC_W), .NUM_CH(NUM_CH)) u_alt_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_set (alt_set),
        .sw_clr (alt_clr),
        .hw_clr ('0),
        .bits   (alt_vec)
    );

    dmaen_err_flag u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_clr (err_clr),
        .hw_set (hw_buserr),
        .flag   (err_q)
    );

    // Read mux; the clear-only registers read back as 0.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_EN_SET:  reg_rdata = en_vec;
            SEL_ALT_SET: reg_rdata = alt_vec;
            SEL_ERR:     reg_rdata = VEC_W'(err_q);
            default:     reg_rdata = '0;
        endcase
    end

    assign chan_en  = en_vec[NUM_CH-1:0];
    assign alt_sel  = alt_vec[NUM_CH-1:0];
    assign err_flag = err_q;

endmodule

// File: rtl/dma_chan_ctrl_bank_chk.sv
module dma_chan_ctrl_bank_chk #(
    parameter int VEC_W  = 32,
    parameter int NUM_CH = 6,
    localparam int CH_W  = $clog2(VEC_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_sel,
    input logic [VEC_W-1:0]  reg_wdata,
    input logic [CH_W-1:0]   hw_chan,
    input logic              hw_done,
    input logic              hw_stop,
    input logic              hw_buserr,
    input logic [NUM_CH-1:0] chan_en,
    input logic [NUM_CH-1:0] alt_sel,
    input logic              err_flag
);

    // R4
    done_kills_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_done && int'(hw_chan) < NUM_CH)
        |=> ((chan_en >> $past(hw_chan)) & NUM_CH'(1)) == '0);

    // R5
    stop_kills_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_stop && int'(hw_chan) < NUM_CH)
        |=> ((chan_en >> $past(hw_chan)) & NUM_CH'(1)) == '0);

    // R6
    buserr_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_buserr |=> err_flag);

    // R2
    en_rise_needs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_sel == 3'd0) |=> (chan_en & ~$past(chan_en)) == '0);

    // R8
    alt_steady_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(alt_sel));

    // R9
    err_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_buserr && !(reg_wr && reg_sel == 3'd4 && reg_wdata[0]))
        |=> err_flag == $past(err_flag));

endmodule

bind dma_chan_ctrl_bank dma_chan_ctrl_bank_chk #(.VEC_W(VEC_W), .NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .hw_chan   (hw_chan),
    .hw_done   (hw_done),
    .hw_stop   (hw_stop),
    .hw_buserr (hw_buserr),
    .chan_en   (chan_en),
    .alt_sel   (alt_sel),
    .err_flag  (err_flag)
);

// File: tb/dma_chan_ctrl_bank_test.sv
module dma_chan_ctrl_bank_test;

    localparam int VEC_W  = 32;
    localparam int NUM_CH = 6;
    localparam int CH_W   = $clog2(VEC_W);
    localparam logic [31:0] MASK = (32'd1 << NUM_CH) - 32'd1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_sel = 3'd0;
    logic [VEC_W-1:0]  reg_wdata = '0;
    logic [VEC_W-1:0]  reg_rdata;
    logic [CH_W-1:0]   hw_chan = '0;
    logic              hw_done = 1'b0, hw_stop = 1'b0, hw_buserr = 1'b0;
    logic [NUM_CH-1:0] chan_en, alt_sel;
    logic              err_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] m_en = '0, m_alt = '0;
    logic        m_err = 1'b0;
    logic [31:0] lfsr = 32'hACE1_2345;

    always #5 clk = ~clk;

    dma_chan_ctrl_bank #(.VEC_W(VEC_W), .NUM_CH(NUM_CH)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_chan(hw_chan),
        .hw_done(hw_done), .hw_stop(hw_stop), .hw_buserr(hw_buserr),
        .chan_en(chan_en), .alt_sel(alt_sel), .err_flag(err_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic next_rand();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        reg_sel = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic outs_chk(input string tag);
        chk(tag, 32'(chan_en), m_en);
        chk(tag, 32'(alt_sel), m_alt);
        chk(tag, 32'(err_flag), 32'(m_err));
        rd_chk(tag, 3'd0, m_en);
        rd_chk(tag, 3'd2, m_alt);
        rd_chk(tag, 3'd4, 32'(m_err));
    endtask

    // One clock step: drive on a falling edge, model at the rising edge, compare at the next falling edge.
    task automatic step(input logic wr, input logic [2:0] a, input logic [31:0] d,
                        input int ch, input logic dn, input logic st, input logic be,
                        input string tag);
        logic [31:0] n_en, n_alt;
        logic        n_err;
        @(negedge clk);
        reg_wr = wr; reg_sel = a; reg_wdata = d;
        hw_chan = CH_W'(ch); hw_done = dn; hw_stop = st; hw_buserr = be;
        n_en = m_en; n_alt = m_alt; n_err = m_err;
        if (wr && a == 3'd0) n_en  = n_en | (d & MASK);
        if (wr && a == 3'd1) n_en  = n_en & ~d;
        if (wr && a == 3'd2) n_alt = n_alt | (d & MASK);
        if (wr && a == 3'd3) n_alt = n_alt & ~d;
        if (wr && a == 3'd4 && d[0]) n_err = 1'b0;
        if ((dn || st || be) && ch < NUM_CH) n_en = n_en & ~(32'd1 << ch);
        if (be) n_err = 1'b1;
        @(posedge clk);
        m_en = n_en; m_alt = n_alt; m_err = n_err;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        hw_done = 1'b0; hw_stop = 1'b0; hw_buserr = 1'b0;
        outs_chk(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        outs_chk("R1");
        rst_n = 1'b1;
        outs_chk("R1");

        // R2 and R3 with pseudo-random patterns; the upper bits hit R11.
        for (int k = 0; k < 24; k++) begin
            next_rand();
            step(1'b1, 3'd0, lfsr, 0, 1'b0, 1'b0, 1'b0, "R2");
            rd_chk("R11", 3'd0, m_en & MASK);
            next_rand();
            step(1'b1, 3'd1, lfsr, 0, 1'b0, 1'b0, 1'b0, "R3");
            rd_chk("R3", 3'd1, 32'd0);
        end

        // R4, R5, R6 for every index, including unimplemented ones (R11).
        for (int ch = 0; ch < 8; ch++) begin
            for (int kind = 0; kind < 3; kind++) begin
                step(1'b1, 3'd0, 32'hFFFF_FFFF, 0, 1'b0, 1'b0, 1'b0, "R2");
                if (ch >= NUM_CH)
                    step(1'b0, 3'd0, 0, ch, kind == 0, kind == 1, kind == 2, "R11");
                else if (kind == 0)
                    step(1'b0, 3'd0, 0, ch, 1'b1, 1'b0, 1'b0, "R4");
                else if (kind == 1)
                    step(1'b0, 3'd0, 0, ch, 1'b0, 1'b1, 1'b0, "R5");
                else
                    step(1'b0, 3'd0, 0, ch, 1'b0, 1'b0, 1'b1, "R6");
                step(1'b1, 3'd4, 32'd1, 0, 1'b0, 1'b0, 1'b0, "R9");
            end
        end

        // R7: hardware disable against a same-cycle set.
        for (int ch = 0; ch < NUM_CH; ch++) begin
            step(1'b1, 3'd1, 32'hFFFF_FFFF, 0, 1'b0, 1'b0, 1'b0, "R3");
            step(1'b1, 3'd0, 32'hFFFF_FFFF, ch, 1'b1, 1'b0, 1'b0, "R7");
        end

        // R8: select set/clear, and events leave selects alone.
        for (int k = 0; k < 16; k++) begin
            next_rand();
            step(1'b1, 3'd2, lfsr, 0, 1'b0, 1'b0, 1'b0, "R8");
            step(1'b0, 3'd0, 0, k % NUM_CH, 1'b1, 1'b0, 1'b1, "R8");
            rd_chk("R8", 3'd3, 32'd0);
            next_rand();
            step(1'b1, 3'd3, lfsr, 0, 1'b0, 1'b0, 1'b0, "R8");
        end

        // R9 and R10: error flag behaviour.
        step(1'b0, 3'd0, 0, 2, 1'b0, 1'b0, 1'b1, "R6");
        step(1'b1, 3'd4, 32'hFFFF_FFFE, 0, 1'b0, 1'b0, 1'b0, "R9");
        step(1'b0, 3'd0, 0, 0, 1'b0, 1'b0, 1'b0, "R9");
        step(1'b1, 3'd4, 32'd1, 3, 1'b0, 1'b0, 1'b1, "R10");
        step(1'b1, 3'd4, 32'd1, 0, 1'b0, 1'b0, 1'b0, "R9");
        step(1'b1, 3'd4, 32'd1, 0, 1'b0, 1'b0, 1'b0, "R9");

        // R12: unused selectors.
        step(1'b1, 3'd0, 32'h0000_0015, 0, 1'b0, 1'b0, 1'b0, "R2");
        step(1'b1, 3'd2, 32'h0000_002A, 0, 1'b0, 1'b0, 1'b0, "R8");
        for (int a = 5; a < 8; a++) begin
            step(1'b1, 3'(a), 32'hFFFF_FFFF, 0, 1'b0, 1'b0, 1'b0, "R12");
            rd_chk("R12", 3'(a), 32'd0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule